// File: doc/BRIEF.md
# Configurable Multilevel Pipeline Register

The block holds four equal-width registers, numbered one to four, that update on a single clock edge. A 2-bit operation code picks how data moves on each edge. With one code the registers act as one four-deep delay line. Two other codes treat them as two separate two-deep pipelines, the head pair (registers one and two) and the tail pair (registers three and four), and load one of the pairs from the shared data input. The last code freezes all four registers.

An elaboration-time parameter picks the behaviour of a split load. In the shifting variant, the second register of the loaded pair takes the old contents of the first. In the holding variant, it keeps its value.

A separate 2-bit read select routes any register to the output through a 4-to-1 multiplexer. The read select does not depend on the operation code, so software-free designs can read one register while writing another in the same cycle. The output is three-state and has an active-low enable.

Top module: `pl_multilevel_reg`

## Requirements
- R1: Operation code 2'b00 shifts all four registers on a clock edge: the data input goes to register 1, register 1 to 2, register 2 to 3 and register 3 to 4.
- R2: Operation code 2'b01 writes the data input into register 3 while registers 1 and 2 keep their values.
- R3: Under code 2'b01, register 4 takes the old value of register 3 when HOLD_SPLIT is 0, and keeps its value when HOLD_SPLIT is 1.
- R4: Operation code 2'b10 writes the data input into register 1 while registers 3 and 4 keep their values.
- R5: Under code 2'b10, register 2 takes the old value of register 1 when HOLD_SPLIT is 0, and keeps its value when HOLD_SPLIT is 1.
- R6: Operation code 2'b11 leaves all four registers unchanged.
- R7: With the output enabled, read select 2'b00 shows register 4, 2'b01 register 3, 2'b10 register 2 and 2'b11 register 1.
- R8: When oe_n is 1, every output bit is high impedance. When oe_n is 0, the output is driven.
- R9: The output is a combinational read that follows the read select in the same cycle whatever the operation code. A register written on an edge shows its new value only after that edge.
- R10: A synchronous active-high reset clears all four registers to zero on the next edge, overriding any operation code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous active-high clear of all registers |
| op | input | 2 | Operation code (00 cascade, 01 load tail, 10 load head, 11 freeze) |
| rd_sel | input | 2 | Read select (00 reg 4, 01 reg 3, 10 reg 2, 11 reg 1) |
| oe_n | input | 1 | Active-low output enable |
| din | input | W | Shared data input |
| dout | output | W | Three-state read data |

## Verification
A write and a read can fall in the same cycle. The bench provokes this by changing the operation code, the data and the read select together on every cycle, with many cycles reading the very register being loaded. The output is sampled after the inputs settle and before the next rising edge, and it must equal the register's pre-edge value held by a behavioural model. Both split-load variants run side by side on the same stimulus. The high-impedance state is judged through a weak pull-down on each output, with a non-zero register selected, so a released bus reads as zero.

// File: rtl/pl_pkg.sv
package pl_pkg;

    localparam int NSTAGE    = 4;
    localparam int SPLIT_IDX = 2;
    localparam int IDX_W     = $clog2(NSTAGE);

    typedef enum logic [1:0] {
        OP_CASCADE   = 2'b00,
        OP_LOAD_TAIL = 2'b01,
        OP_LOAD_HEAD = 2'b10,
        OP_FREEZE    = 2'b11
    } pl_op_e;

    typedef struct packed {
        logic [NSTAGE-1:0] en;
        logic              mid_from_din;
    } pl_ctrl_t;

    function automatic pl_ctrl_t decode_op(pl_op_e op, logic hold_split);
        pl_ctrl_t c;
        c.en           = '0;
        c.mid_from_din = 1'b0;
        unique case (op)
            OP_CASCADE: begin
                c.en = '1;
            end
            OP_LOAD_TAIL: begin
                c.en[SPLIT_IDX]   = 1'b1;
                c.en[NSTAGE-1]    = ~hold_split;
                c.mid_from_din    = 1'b1;
            end
            OP_LOAD_HEAD: begin
                c.en[0] = 1'b1;
                c.en[1] = ~hold_split;
            end
            default: begin
                c.en = '0;
            end
        endcase
        return c;
    endfunction

    function automatic logic [IDX_W-1:0] sel_to_idx(logic [1:0] s);
        return ~s;
    endfunction

endpackage

// File: rtl/pl_decode.sv
module pl_decode
    import pl_pkg::*;
#(
    parameter bit HOLD_SPLIT = 1'b0
) (
    input  logic [1:0] op,
    output pl_ctrl_t   ctrl
);
    always_comb begin
        ctrl = decode_op(pl_op_e'(op), HOLD_SPLIT);
    end
endmodule

// File: rtl/pl_bank.sv
module pl_bank
    import pl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  pl_ctrl_t                ctrl,
    input  logic [W-1:0]            din,
    output logic [NSTAGE-1:0][W-1:0] q
);
    logic [NSTAGE-1:0][W-1:0] src;

    for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign src[k] = din;
        end else if (k == SPLIT_IDX) begin : g_mid
            assign src[k] = ctrl.mid_from_din ? din : q[k-1];
        end else begin : g_chain
            assign src[k] = q[k-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                q[k] <= '0;
            end else if (ctrl.en[k]) begin
                q[k] <= src[k];
            end
        end
    end
endmodule

// File: rtl/pl_readsel.sv
module pl_readsel
    import pl_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [NSTAGE-1:0][W-1:0] q,
    input  logic [1:0]               rd_sel,
    input  logic                     oe_n,
    output wire  [W-1:0]             dout
);
    logic [W-1:0] rd_word;

    always_comb begin
        rd_word = q[sel_to_idx(rd_sel)];
    end

    assign dout = oe_n ? {W{1'bz}} : rd_word;
endmodule

// File: rtl/pl_multilevel_reg.sv
module pl_multilevel_reg
    import pl_pkg::*;
#(
    parameter int W          = 8,
    parameter bit HOLD_SPLIT = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [1:0]   op,
    input  logic [1:0]   rd_sel,
    input  logic         oe_n,
    input  logic [W-1:0] din,
    output wire  [W-1:0] dout
);
    pl_ctrl_t                ctrl;
    logic [NSTAGE-1:0][W-1:0] stage_q;

    pl_decode #(.HOLD_SPLIT(HOLD_SPLIT)) u_dec (
        .op   (op),
        .ctrl (ctrl)
    );

    pl_bank #(.W(W)) u_bank (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl),
        .din  (din),
        .q    (stage_q)
    );

    pl_readsel #(.W(W)) u_rd (
        .q      (stage_q),
        .rd_sel (rd_sel),
        .oe_n   (oe_n),
        .dout   (dout)
    );
endmodule

// File: rtl/pl_multilevel_reg_chk.sv
module pl_multilevel_reg_chk
    import pl_pkg::*;
#(
    parameter int W          = 8,
    parameter bit HOLD_SPLIT = 1'b0
) (
    input logic                     clk,
    input logic                     rst,
    input logic [1:0]               op,
    input logic [1:0]               rd_sel,
    input logic                     oe_n,
    input logic [W-1:0]             din,
    input logic [NSTAGE-1:0][W-1:0] stage_q
);
    AST_CASCADE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        op == 2'b00 |=> stage_q[0] == $past(din) && stage_q[1] == $past(stage_q[0])
                     && stage_q[2] == $past(stage_q[1]) && stage_q[3] == $past(stage_q[2])); // R1

    AST_TAIL_LOAD: assert property (@(posedge clk) disable iff (rst)
        op == 2'b01 |=> stage_q[2] == $past(din) && $stable(stage_q[0]) && $stable(stage_q[1])); // R2

    AST_HEAD_LOAD: assert property (@(posedge clk) disable iff (rst)
        op == 2'b10 |=> stage_q[0] == $past(din) && $stable(stage_q[2]) && $stable(stage_q[3])); // R4

    if (HOLD_SPLIT) begin : g_hold
        AST_TAIL_SECOND_HOLDS: assert property (@(posedge clk) disable iff (rst)
            op == 2'b01 |=> $stable(stage_q[3])); // R3
        AST_HEAD_SECOND_HOLDS: assert property (@(posedge clk) disable iff (rst)
            op == 2'b10 |=> $stable(stage_q[1])); // R5
    end else begin : g_shift
        AST_TAIL_SECOND_SHIFTS: assert property (@(posedge clk) disable iff (rst)
            op == 2'b01 |=> stage_q[3] == $past(stage_q[2])); // R3
        AST_HEAD_SECOND_SHIFTS: assert property (@(posedge clk) disable iff (rst)
            op == 2'b10 |=> stage_q[1] == $past(stage_q[0])); // R5
    end

    AST_FREEZE_ALL: assert property (@(posedge clk) disable iff (rst)
        op == 2'b11 |=> $stable(stage_q)); // R6

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> stage_q == '0); // R10
endmodule

bind pl_multilevel_reg pl_multilevel_reg_chk #(.W(W), .HOLD_SPLIT(HOLD_SPLIT)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .rd_sel  (rd_sel),
    .oe_n    (oe_n),
    .din     (din),
    .stage_q (stage_q)
);

// File: tb/sim_pl_multilevel_reg.sv
`timescale 1ns/1ps
module sim_pl_multilevel_reg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [1:0]   op = 2'b11;
    logic [1:0]   rd_sel = 2'b00;
    logic         oe_n = 1'b1;
    logic [W-1:0] din = '0;
    wire  [W-1:0] y0;
    wire  [W-1:0] y1;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] m [2][4];

    always #5 clk = ~clk;

    // shifting variant
    pl_multilevel_reg #(.W(W), .HOLD_SPLIT(1'b0)) u0 (
        .clk(clk), .rst(rst), .op(op), .rd_sel(rd_sel), .oe_n(oe_n), .din(din), .dout(y0));
    // holding variant
    pl_multilevel_reg #(.W(W), .HOLD_SPLIT(1'b1)) u1 (
        .clk(clk), .rst(rst), .op(op), .rd_sel(rd_sel), .oe_n(oe_n), .din(din), .dout(y1));

    for (genvar i = 0; i < W; i++) begin : g_pd
        pulldown (y0[i]);
        pulldown (y1[i]);
    end

    task automatic check_out(input string tag);
        for (int v = 0; v < 2; v++) begin
            logic [W-1:0] exp_v;
            logic [W-1:0] act_v;
            exp_v = oe_n ? '0 : m[v][3 - rd_sel];
            act_v = (v == 0) ? y0 : y1;
            n_cmp++;
            if (act_v !== exp_v) begin
                n_bad++;
                $display("FAIL %s variant=%0d op=%b sel=%b oe_n=%b actual=%h expected=%h",
                         tag, v, op, rd_sel, oe_n, act_v, exp_v);
            end
        end
    endtask

    task automatic model_edge(input logic [1:0] o, input logic [W-1:0] d, input logic r);
        for (int v = 0; v < 2; v++) begin
            if (r) begin
                for (int k = 0; k < 4; k++) m[v][k] = '0;
            end else begin
                case (o)
                    2'b00: begin
                        m[v][3] = m[v][2]; m[v][2] = m[v][1];
                        m[v][1] = m[v][0]; m[v][0] = d;
                    end
                    2'b01: begin
                        if (v == 0) m[v][3] = m[v][2];
                        m[v][2] = d;
                    end
                    2'b10: begin
                        if (v == 0) m[v][1] = m[v][0];
                        m[v][0] = d;
                    end
                    default: ;
                endcase
            end
        end
    endtask

    // drive at negedge, check before the edge (pre-edge value), then apply edge to model
    task automatic step(input logic [1:0] o, input logic [W-1:0] d,
                        input logic [1:0] s, input logic oe, input string tag);
        op = o; din = d; rd_sel = s; oe_n = oe;
        #1;
        check_out(tag);
        @(posedge clk);
        model_edge(o, d, rst);
        @(negedge clk);
    endtask

    task automatic read_all(input string tag);
        for (int s = 0; s < 4; s++) step(2'b11, 8'h00, s[1:0], 1'b0, tag);
    endtask

    initial begin
        for (int v = 0; v < 2; v++) for (int k = 0; k < 4; k++) m[v][k] = 'x;
        @(negedge clk);
        step(2'b00, 8'hAA, 2'b00, 1'b1, "R8");
        model_edge(2'b00, 8'h00, 1'b1);
        rst = 1'b0;
        // reset state, every register reads zero
        read_all("R10");
        // cascade fill
        step(2'b00, 8'h11, 2'b11, 1'b0, "R1");
        step(2'b00, 8'h22, 2'b11, 1'b0, "R1");
        step(2'b00, 8'h33, 2'b10, 1'b0, "R1");
        step(2'b00, 8'h44, 2'b01, 1'b0, "R1");
        read_all("R7");
        // tail load, variant difference on register 4
        step(2'b01, 8'h5A, 2'b01, 1'b0, "R9");
        read_all("R2");
        step(2'b01, 8'h6B, 2'b00, 1'b0, "R3");
        step(2'b11, 8'h00, 2'b00, 1'b0, "R3");
        // head load, variant difference on register 2
        step(2'b10, 8'h7C, 2'b11, 1'b0, "R9");
        step(2'b10, 8'h8D, 2'b10, 1'b0, "R5");
        step(2'b11, 8'h00, 2'b10, 1'b0, "R5");
        read_all("R4");
        // freeze with data changing
        step(2'b11, 8'hFF, 2'b11, 1'b0, "R6");
        step(2'b11, 8'hEE, 2'b00, 1'b0, "R6");
        read_all("R6");
        // output released with non-zero contents
        for (int s = 0; s < 4; s++) step(2'b11, 8'h00, s[1:0], 1'b1, "R8");
        // mixed traffic
        for (int i = 0; i < 400; i++) begin
            logic [1:0] o;
            o = 2'($urandom_range(0, 3));
            step(o, 8'($urandom), 2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0),
                 (o == 2'b00) ? "R1" : (o == 2'b01) ? "R2" : (o == 2'b10) ? "R4" : "R6");
        end
        // reset mid-run overrides a cascade code
        rst = 1'b1;
        step(2'b00, 8'h99, 2'b11, 1'b0, "R10");
        rst = 1'b0;
        read_all("R10");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule